// File: doc/BRIEF.md
# Deep Power-Down Sequencer

This block drives the power-control enable of an asynchronous pseudo-static memory. A high enable means the memory runs normally. A low enable puts it into deep power-down, where it keeps none of its contents. The block counts every timing interval in cycles of a free-running clock. It holds the enable low while the supply settles after power-good rises. It keeps the enable low for the minimum deep power-down time once it has been dropped. After the enable rises again, it blocks every access for the recovery hold.

The access controller makes single-cycle requests to enter or leave deep power-down. It reports whether an access is in flight and whether the memory's chip select is deasserted. The block changes the power enable only while chip select is deasserted. It signals with a ready level when cycles may be issued. It raises a one-cycle data-lost pulse at the moment ready returns, because every stored word is invalid at that point. Each interval is a nanosecond parameter. The block turns it into a cycle count by rounding up against a clock-period parameter given in picoseconds.

Top module: `dpd_sequencer`

## Requirements
- R1: While reset is asserted, and on release with power-good low, the enable `ce2`, `ready` and `dataLost` are all low.
- R2: After power-good is first sampled high, `ce2` stays low for exactly ceil(POWERON_NS*1000/CLK_PERIOD_PS) cycles before it rises, provided chip select is deasserted (`ce1High`=1).
- R3: `ce2` changes level only on an edge where `ce1High` was sampled 1. If `ce1High` is low when an interval ends, the rise waits until the edge at which `ce1High` is sampled 1 again. The one exception is loss of power-good.
- R4: After `ce2` rises, `ready` stays low for exactly ceil(RECOVER_NS*1000/CLK_PERIOD_PS) cycles and then goes high.
- R5: `ready` is high only in normal operation after the recovery hold has expired. It is never high while `ce2` is low, while an entry is pending, or during recovery.
- R6: An `enterReq` pulse in normal operation drops `ready` on the next cycle. When `accessIdle` is 0, the fall of `ce2` is held off until the edge at which `accessIdle` is sampled 1.
- R7: Once `ce2` falls for deep power-down, it stays low for at least M = ceil(MIN_LOW_NS*1000/CLK_PERIOD_PS) cycles. A `leaveReq` that arrives earlier is remembered, and `ce2` then rises after exactly M cycles.
- R8: A `leaveReq` pulse that arrives after the minimum low time makes `ce2` rise on the same edge at which the pulse is sampled.
- R9: `dataLost` is a one-cycle pulse in the first cycle of `ready` high after every power-up or deep power-down exit, and it is low otherwise.
- R10: When power-good is sampled low, `ce2` and `ready` are low from the next cycle on. The power-on interval then restarts when power-good returns.
- R11: A `leaveReq` outside deep power-down, or an `enterReq` outside normal operation (power-on or recovery), has no effect on `ce2`, `ready` or the interval lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerGood | input | 1 | Supply has reached its minimum level |
| ce1High | input | 1 | Memory chip select is deasserted (high) |
| accessIdle | input | 1 | No memory access in progress |
| enterReq | input | 1 | One-cycle request to enter deep power-down |
| leaveReq | input | 1 | One-cycle request to leave deep power-down |
| ce2 | output | 1 | Memory power enable, high = normal, low = power-down |
| ready | output | 1 | Accesses may be issued |
| dataLost | output | 1 | One-cycle pulse: all earlier contents are invalid |

## Verification
The bench randomises three things in each deep power-down round: when the leave request arrives relative to the minimum low time, how long chip select stays asserted, and whether an access is still in flight at entry. A design that drops an early leave request would keep the enable low forever. A design that acts on it at once would cut the low pulse short. An off-by-one counter shows up as a low or recovery length that misses the rounded-up count by one cycle. The bench also sends stray requests during power-on and recovery, drops power-good in normal operation, and holds chip select asserted past the power-on interval. These cases expose a design that leaves an interval early, fails to restart the power-on interval, or moves the enable while chip select is low.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

  typedef enum logic [2:0] {
    ST_OFF, ST_PWRON, ST_WAKE, ST_RECOVER, ST_RUN, ST_DRAIN, ST_DPD
  } seqState_e;

  typedef enum logic [1:0] {
    IV_PWRON, IV_MINLOW, IV_RECOVER
  } interval_e;

  // strobes from control to the interval timer
  typedef struct packed {
    logic      load;
    interval_e sel;
  } timerCtl_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic longint unsigned toCycles(input longint unsigned ns,
                                               input longint unsigned periodPs);
    longint unsigned c;
    c = (ns * 64'd1000 + periodPs - 64'd1) / periodPs;
    return (c == 0) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/dpd_timer.sv
module dpd_timer
  import dpd_pkg::*;
#(
  parameter int unsigned     CNT_W       = 8,
  parameter longint unsigned PWRON_CYC   = 8,
  parameter longint unsigned MINLOW_CYC  = 8,
  parameter longint unsigned RECOVER_CYC = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCtl_t ctl,
  output logic      done
);

  localparam logic [CNT_W-1:0] PWRON_LD   = CNT_W'(PWRON_CYC - 1);
  localparam logic [CNT_W-1:0] MINLOW_LD  = CNT_W'(MINLOW_CYC - 1);
  localparam logic [CNT_W-1:0] RECOVER_LD = CNT_W'(RECOVER_CYC - 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (ctl.sel)
      IV_PWRON:  loadVal = PWRON_LD;
      IV_MINLOW: loadVal = MINLOW_LD;
      default:   loadVal = RECOVER_LD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 count <= '0;
    else if (ctl.load)         count <= loadVal;
    else if (count != '0)      count <= count - 1'b1;
  end

  assign done = (count == '0);

endmodule

// File: rtl/dpd_ctrl.sv
module dpd_ctrl
  import dpd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      powerGood,
  input  logic      ce1High,
  input  logic      accessIdle,
  input  logic      enterReq,
  input  logic      leaveReq,
  input  logic      done,
  output timerCtl_t tctl,
  output logic      ce2,
  output logic      ready,
  output logic      dataLost
);

  seqState_e state, nextState;
  logic      leavePend;
  logic      justUp;

  always_comb begin
    nextState = state;
    if (!powerGood) begin
      nextState = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:     nextState = ST_PWRON;
        ST_PWRON:   if (done) nextState = ce1High ? ST_RECOVER : ST_WAKE;
        ST_WAKE:    if (ce1High) nextState = ST_RECOVER;
        ST_RECOVER: if (done) nextState = ST_RUN;
        ST_RUN:     if (enterReq)
                      nextState = (accessIdle && ce1High) ? ST_DPD : ST_DRAIN;
        ST_DRAIN:   if (accessIdle && ce1High) nextState = ST_DPD;
        ST_DPD:     if (done && (leavePend || leaveReq))
                      nextState = ce1High ? ST_RECOVER : ST_WAKE;
        default:    nextState = ST_OFF;
      endcase
    end
  end

  // timer reload on entry into any timed state
  always_comb begin
    tctl.load = 1'b0;
    tctl.sel  = IV_PWRON;
    if (nextState != state) begin
      unique case (nextState)
        ST_PWRON:   begin tctl.load = 1'b1; tctl.sel = IV_PWRON;   end
        ST_RECOVER: begin tctl.load = 1'b1; tctl.sel = IV_RECOVER; end
        ST_DPD:     begin tctl.load = 1'b1; tctl.sel = IV_MINLOW;  end
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      leavePend <= 1'b0;
      justUp    <= 1'b0;
    end else begin
      state     <= nextState;
      leavePend <= (state == ST_DPD) && (nextState == ST_DPD) && (leavePend || leaveReq);
      justUp    <= (nextState == ST_RUN) && (state != ST_RUN);
    end
  end

  assign ce2      = (state == ST_RECOVER) || (state == ST_RUN) || (state == ST_DRAIN);
  assign ready    = (state == ST_RUN);
  assign dataLost = justUp && ready;

  assert_ce2_moves_deselected_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((ce2 != $past(ce2)) && $past(powerGood)) |-> $past(ce1High));

  assert_ready_needs_ce2_R5: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> ce2);

  assert_datalost_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    dataLost |=> !dataLost);

  assert_datalost_with_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    dataLost |-> ($rose(ready) && $past(ce2)));

  assert_power_loss_R10: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> (!ce2 && !ready));

  assert_enter_drops_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ready && enterReq && powerGood) |=> !ready);

endmodule

// File: rtl/dpd_sequencer.sv
module dpd_sequencer
  import dpd_pkg::*;
#(
  parameter longint unsigned CLK_PERIOD_PS = 4000,
  parameter longint unsigned POWERON_NS    = 30000,
  parameter longint unsigned MIN_LOW_NS    = 10000000,
  parameter longint unsigned RECOVER_NS    = 300000
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerGood,
  input  logic ce1High,
  input  logic accessIdle,
  input  logic enterReq,
  input  logic leaveReq,
  output logic ce2,
  output logic ready,
  output logic dataLost
);

  localparam longint unsigned PWRON_CYC   = toCycles(POWERON_NS, CLK_PERIOD_PS);
  localparam longint unsigned MINLOW_CYC  = toCycles(MIN_LOW_NS, CLK_PERIOD_PS);
  localparam longint unsigned RECOVER_CYC = toCycles(RECOVER_NS, CLK_PERIOD_PS);
  localparam longint unsigned MAX_A       = (PWRON_CYC > MINLOW_CYC) ? PWRON_CYC : MINLOW_CYC;
  localparam longint unsigned MAX_CYC     = (MAX_A > RECOVER_CYC) ? MAX_A : RECOVER_CYC;
  localparam int unsigned     CNT_W       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  timerCtl_t tctl;
  logic      done;

  dpd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerGood  (powerGood),
    .ce1High    (ce1High),
    .accessIdle (accessIdle),
    .enterReq   (enterReq),
    .leaveReq   (leaveReq),
    .done       (done),
    .tctl       (tctl),
    .ce2        (ce2),
    .ready      (ready),
    .dataLost   (dataLost)
  );

  dpd_timer #(
    .CNT_W       (CNT_W),
    .PWRON_CYC   (PWRON_CYC),
    .MINLOW_CYC  (MINLOW_CYC),
    .RECOVER_CYC (RECOVER_CYC)
  ) u_timer (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (tctl),
    .done (done)
  );

endmodule

// File: tb/dpd_sequencer_bench.sv
module dpd_sequencer_bench;

  localparam longint unsigned PER_PS = 4000;
  localparam longint unsigned PON_NS = 118;
  localparam longint unsigned MIN_NS = 401;
  localparam longint unsigned REC_NS = 197;

  function automatic int ceilCyc(input longint unsigned ns);
    return int'((ns * 1000 + PER_PS - 1) / PER_PS);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  localparam int P = 30;   // ceil(118000/4000)
  localparam int M = 101;  // ceil(401000/4000)
  localparam int R = 50;   // ceil(197000/4000)

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerGood = 1'b0, ce1High = 1'b1, accessIdle = 1'b1;
  logic enterReq = 1'b0, leaveReq = 1'b0;
  logic ce2, ready, dataLost;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dpd_sequencer #(
    .CLK_PERIOD_PS (PER_PS),
    .POWERON_NS    (PON_NS),
    .MIN_LOW_NS    (MIN_NS),
    .RECOVER_NS    (REC_NS)
  ) u_dpd_sequencer (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .ce1High(ce1High),
    .accessIdle(accessIdle), .enterReq(enterReq), .leaveReq(leaveReq),
    .ce2(ce2), .ready(ready), .dataLost(dataLost)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // at a negedge where ce2 was just seen high: recovery length and data-lost pulse
  task automatic checkRecover(input bit stray);
    int r = 0;
    while (!ready && r < R + 200) begin
      if (dataLost) check("R9 dataLost early", 1, 0);
      r++;
      enterReq = stray && (r == 2);
      leaveReq = stray && (r == 4);
      step();
    end
    enterReq = 1'b0; leaveReq = 1'b0;
    check("R4 recovery cycles", r, R);
    check("R9 dataLost on ready rise", dataLost, 1);
    step();
    check("R9 dataLost drops", dataLost, 0);
  endtask

  task automatic powerUp(input int c);
    int n = 0;
    powerGood = 1'b1;
    ce1High   = (c == 0);
    forever begin
      step();
      enterReq = 1'b0;
      if (ce2 || n > P + c + 50) break;
      if (ready) check("R5 ready while ce2 low", 1, 0);
      n++;
      if (n == c) ce1High = 1'b1;
      if (n == 3) enterReq = 1'b1;  // stray, R11
    end
    ce1High = 1'b1;
    check("R2/R3 power-on low cycles", n, max3(P, c, 0));
    checkRecover(1'b1);
  endtask

  task automatic dpdRound(input bit idle, input int drain, input int j, input int c);
    int n = 0;
    accessIdle = idle;
    enterReq   = 1'b1;
    if (!idle) begin
      step();
      enterReq = 1'b0;
      for (int k = 0; k < drain; k++) begin
        check("R6 ce2 held during access", ce2, 1);
        check("R5 ready low while pending", ready, 0);
        step();
      end
      accessIdle = 1'b1;
    end
    forever begin
      step();
      enterReq = 1'b0;
      leaveReq = 1'b0;
      if (ce2 || n > M + j + c + 50) break;
      if (ready) check("R5 ready while ce2 low", 1, 0);
      n++;
      if (n == 1) ce1High = (c == 0);
      if (n == c) ce1High = 1'b1;
      if (n == j) leaveReq = 1'b1;
    end
    ce1High = 1'b1;
    check("R7/R8/R3 deep power-down low cycles", n, max3(M, j, c));
    checkRecover(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    check("R2 conversion P", ceilCyc(PON_NS), P);
    check("R7 conversion M", ceilCyc(MIN_NS), M);
    check("R4 conversion R", ceilCyc(REC_NS), R);
    repeat (3) step();
    check("R1 ce2 in reset", ce2, 0);
    check("R1 ready in reset", ready, 0);
    check("R1 dataLost in reset", dataLost, 0);
    rstN = 1'b1;
    repeat (5) step();
    check("R1 ce2 after reset no power", ce2, 0);
    check("R1 ready after reset no power", ready, 0);

    powerUp(0);

    // leave request while running is ignored (R11)
    leaveReq = 1'b1; step(); leaveReq = 1'b0;
    repeat (5) step();
    check("R11 ce2 after stray leave", ce2, 1);
    check("R11 ready after stray leave", ready, 1);

    // directed corners: early leave, leave at the limit, late leave, chip select held
    dpdRound(1'b1, 0, 1, 0);
    dpdRound(1'b1, 0, M, 0);
    dpdRound(1'b0, 7, M + 1, 0);
    dpdRound(1'b1, 0, 10, M + 15);

    for (int it = 0; it < 8; it++) begin
      bit idle  = $urandom_range(0, 1) == 1;
      int drain = $urandom_range(1, 20);
      int j     = $urandom_range(1, M + 40);
      int c     = ($urandom_range(0, 2) == 0) ? $urandom_range(2, M + 40) : 0;
      dpdRound(idle, drain, j, c);
    end

    // power loss in normal operation, then restart with chip select held (R10, R3)
    powerGood = 1'b0;
    step();
    check("R10 ce2 after power loss", ce2, 0);
    check("R10 ready after power loss", ready, 0);
    repeat (4) step();
    powerUp(P + 12);
    powerGood = 1'b0;
    step();
    check("R10 ce2 after second loss", ce2, 0);
    powerUp(0);

    summary();
  end

endmodule